// File: doc/BRIEF.md
# Tiled Matrix Read Address Sequencer

This block generates the read addresses a DMA engine needs to pull a matrix, stored row-major in a linear buffer at address `row*COLS + col`, out as a stream of small rectangular tiles. The elements of each tile come out back to back, so a compute engine downstream receives one whole sub-matrix per burst and can place it at consecutive destination addresses.

A single-cycle `start` pulse loads five run-time settings: matrix rows and columns, tile rows and columns, and the walk order of the tiles. With the walk order at 0, all tiles of one block row come out before the next block row begins, which suits a left operand. With the walk order at 1, all tiles of one block column come out before the next block column begins, which suits a right operand. Inside a tile the elements always go row by row. One address is offered per cycle under a valid/ready handshake. A flag marks the last address of each tile and another marks the last address of the matrix. A setting that does not divide evenly into tiles is refused and reported on an error output.

Top module: `tile_addr_gen`

## Requirements
- R1: After reset the block is idle, with `addr_valid`, `busy` and `cfg_err` all 0.
- R2: A `start` pulse while idle, with a valid setting, makes `busy` and `addr_valid` 1 from the next cycle, and the first address offered is 0.
- R3: Inside a tile the addresses follow `(tile_row_base + r)*cols + tile_col_base + c`, with `c` running fastest from 0 to tile_cols-1 and then `r` advancing from 0 to tile_rows-1.
- R4: With `cfg_walk_down` = 0 the tile column base advances first and the tile row base advances only when a block row is finished. For a 64x64 matrix with 4x16 tiles, the second tile begins at address 16 and the first tile of the second block row begins at address 256.
- R5: With `cfg_walk_down` = 1 the tile row base advances first and the tile column base advances only when a block column is finished. For a 64x64 matrix with 16x8 tiles, the second tile begins at address 1024 and the fifth tile begins at address 8.
- R6: `tile_last` is 1 exactly on the final address of every tile.
- R7: `frame_last` is 1 only on the final address of the matrix, which is the rows*cols-th address offered. After that address is accepted, `addr_valid` and `busy` are 0 in the next cycle.
- R8: While `addr_valid` is 1 and `addr_ready` is 0, `addr`, `tile_last` and `frame_last` hold their values, and the sequence advances only on a cycle with both valid and ready at 1.
- R9: A `start` pulse is refused when any dimension is zero, or when rows is not a multiple of tile rows, or when cols is not a multiple of tile cols. A refused start sets `cfg_err` to 1, and `addr_valid` stays 0. The next accepted start clears `cfg_err`.
- R10: While `busy` is 1, a `start` pulse and any change on the setting inputs have no effect on the address sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load the setting and begin a matrix |
| cfg_rows | input | 9 | Matrix rows |
| cfg_cols | input | 9 | Matrix columns |
| cfg_tile_rows | input | 9 | Tile rows |
| cfg_tile_cols | input | 9 | Tile columns |
| cfg_walk_down | input | 1 | Tile walk order: 0 across block rows, 1 down block columns |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | Address is offered |
| addr | output | 18 | Element read address |
| tile_last | output | 1 | Final address of a tile |
| frame_last | output | 1 | Final address of the matrix |
| busy | output | 1 | A matrix is being walked |
| cfg_err | output | 1 | Last start was refused |

## Verification
The bench targets the two carry points of the walk: the step from the last element of a tile into the next tile, and the step from the last tile of a block row or column into the next one. A design with a wrong carry repeats or skips a tile, or jumps to the wrong block row. Both walk orders run with tile shapes of one row, one column and a full-width strip, and the anchor addresses 16, 256, 1024 and 8 are checked directly. Stalls under random ready show whether the counters wrongly advance without a handshake. A start and changed settings are injected in the middle of a matrix to show whether the sequence is disturbed. Settings that do not divide evenly, and zero settings, are tried to show whether a bad setting is walked when it should be refused.

// File: rtl/tagen_pkg.sv
`timescale 1ns/1ps
package tagen_pkg;

    localparam int DIM_W  = 9;
    localparam int ADDR_W = 2 * DIM_W;

    typedef enum logic {
        WALK_ACROSS = 1'b0,
        WALK_DOWN   = 1'b1
    } walk_e;

    typedef struct packed {
        logic [DIM_W-1:0] rows;
        logic [DIM_W-1:0] cols;
        logic [DIM_W-1:0] trows;
        logic [DIM_W-1:0] tcols;
        walk_e            walk;
    } cfg_t;

    typedef struct packed {
        logic [DIM_W-1:0] rbase;
        logic [DIM_W-1:0] cbase;
        logic [DIM_W-1:0] er;
        logic [DIM_W-1:0] ec;
    } pos_t;

    function automatic logic cfg_ok(cfg_t c);
        if (c.rows == '0 || c.cols == '0 || c.trows == '0 || c.tcols == '0)
            return 1'b0;
        return ((c.rows % c.trows) == '0) && ((c.cols % c.tcols) == '0);
    endfunction

endpackage

// File: rtl/tagen_ctrl.sv
`timescale 1ns/1ps
module tagen_ctrl
    import tagen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  cfg_t cfg_in,
    input  logic done,
    output logic busy,
    output logic load,
    output logic cfg_err,
    output cfg_t cfg_q
);

    logic ok;

    assign ok   = cfg_ok(cfg_in);
    assign load = start && !busy && ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cfg_err <= 1'b0;
            cfg_q   <= '0;
        end else begin
            if (load) begin
                busy  <= 1'b1;
                cfg_q <= cfg_in;
            end else if (done) begin
                busy  <= 1'b0;
            end
            if (start && !busy)
                cfg_err <= !ok;
        end
    end

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q));

    // R9
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy);

endmodule

// File: rtl/tagen_walk.sv
`timescale 1ns/1ps
module tagen_walk
    import tagen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic adv,
    input  cfg_t cfg,
    output pos_t pos,
    output logic tile_last,
    output logic frame_last
);

    localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

    pos_t           pos_q, pos_d;
    logic [DIM_W:0] rnext, cnext;
    logic           row_end, col_end, ec_end, er_end;

    assign rnext   = {1'b0, pos_q.rbase} + {1'b0, cfg.trows};
    assign cnext   = {1'b0, pos_q.cbase} + {1'b0, cfg.tcols};
    assign row_end = (rnext == {1'b0, cfg.rows});
    assign col_end = (cnext == {1'b0, cfg.cols});
    assign ec_end  = (pos_q.ec == cfg.tcols - ONE);
    assign er_end  = (pos_q.er == cfg.trows - ONE);

    assign tile_last  = ec_end && er_end;
    assign frame_last = tile_last && row_end && col_end;
    assign pos        = pos_q;

    always_comb begin
        pos_d = pos_q;
        if (!ec_end) begin
            pos_d.ec = pos_q.ec + ONE;
        end else begin
            pos_d.ec = '0;
            if (!er_end) begin
                pos_d.er = pos_q.er + ONE;
            end else begin
                pos_d.er = '0;
                if (cfg.walk == WALK_ACROSS) begin
                    if (!col_end) begin
                        pos_d.cbase = cnext[DIM_W-1:0];
                    end else begin
                        pos_d.cbase = '0;
                        pos_d.rbase = row_end ? '0 : rnext[DIM_W-1:0];
                    end
                end else begin
                    if (!row_end) begin
                        pos_d.rbase = rnext[DIM_W-1:0];
                    end else begin
                        pos_d.rbase = '0;
                        pos_d.cbase = col_end ? '0 : cnext[DIM_W-1:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load)
            pos_q <= '0;
        else if (adv)
            pos_q <= pos_d;
    end

    // R8
    pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> $stable(pos_q));

    // R6
    tile_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && tile_last && !load) |=> (pos_q.er == '0 && pos_q.ec == '0));

endmodule

// File: rtl/tagen_addr.sv
`timescale 1ns/1ps
module tagen_addr
    import tagen_pkg::*;
(
    input  pos_t              pos,
    input  logic [DIM_W-1:0]  cols,
    output logic [ADDR_W-1:0] addr
);

    logic [DIM_W-1:0]  row_idx;
    logic [DIM_W-1:0]  col_idx;
    logic [ADDR_W-1:0] row_off;

    assign row_idx = pos.rbase + pos.er;
    assign col_idx = pos.cbase + pos.ec;
    assign row_off = ADDR_W'(row_idx) * ADDR_W'(cols);
    assign addr    = row_off + ADDR_W'(col_idx);

endmodule

// File: rtl/tile_addr_gen.sv
`timescale 1ns/1ps
module tile_addr_gen
    import tagen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIM_W-1:0]  cfg_rows,
    input  logic [DIM_W-1:0]  cfg_cols,
    input  logic [DIM_W-1:0]  cfg_tile_rows,
    input  logic [DIM_W-1:0]  cfg_tile_cols,
    input  logic              cfg_walk_down,
    input  logic              addr_ready,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic              tile_last,
    output logic              frame_last,
    output logic              busy,
    output logic              cfg_err
);

    cfg_t cfg_in, cfg_q;
    pos_t pos;
    logic load, adv, t_last, f_last;

    assign cfg_in = '{rows:  cfg_rows,  cols:  cfg_cols,
                      trows: cfg_tile_rows, tcols: cfg_tile_cols,
                      walk:  walk_e'(cfg_walk_down)};

    assign adv = busy && addr_ready;

    tagen_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cfg_in  (cfg_in),
        .done    (adv && f_last),
        .busy    (busy),
        .load    (load),
        .cfg_err (cfg_err),
        .cfg_q   (cfg_q)
    );

    tagen_walk u_walk (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .adv        (adv),
        .cfg        (cfg_q),
        .pos        (pos),
        .tile_last  (t_last),
        .frame_last (f_last)
    );

    tagen_addr u_addr (
        .pos  (pos),
        .cols (cfg_q.cols),
        .addr (addr)
    );

    assign addr_valid = busy;
    assign tile_last  = busy && t_last;
    assign frame_last = busy && f_last;

    // R2
    first_addr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_valid) |-> (addr == '0));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr) && $stable(tile_last)));

    // R7
    frame_end_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_ready && frame_last) |=> !addr_valid);

    // R7
    last_nest_chk: assert property (@(posedge clk) disable iff (rst)
        frame_last |-> tile_last);

    // R3
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> (addr < ADDR_W'(cfg_q.rows) * ADDR_W'(cfg_q.cols)));

endmodule

// File: tb/tile_addr_gen_tb.sv
`timescale 1ns/1ps
module tile_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [8:0]  cfg_rows = '0, cfg_cols = '0, cfg_tile_rows = '0, cfg_tile_cols = '0;
    logic        cfg_walk_down = 1'b0;
    logic        addr_ready = 1'b0;
    logic        addr_valid;
    logic [17:0] addr;
    logic        tile_last, frame_last, busy, cfg_err;

    int checks = 0;
    int fails  = 0;
    int log_addr [0:4095];

    always #5 clk = ~clk;

    tile_addr_gen u_dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
        .cfg_tile_rows(cfg_tile_rows), .cfg_tile_cols(cfg_tile_cols),
        .cfg_walk_down(cfg_walk_down), .addr_ready(addr_ready),
        .addr_valid(addr_valid), .addr(addr), .tile_last(tile_last),
        .frame_last(frame_last), .busy(busy), .cfg_err(cfg_err)
    );

    function automatic int model_addr(int k, int rows, int cols, int tr, int tc, bit down);
        int te, t, w, er, ec, ti_r, ti_c;
        te = tr * tc;
        t  = k / te;
        w  = k % te;
        er = w / tc;
        ec = w % tc;
        if (!down) begin
            ti_r = t / (cols / tc);
            ti_c = t % (cols / tc);
        end else begin
            ti_c = t / (rows / tr);
            ti_r = t % (rows / tr);
        end
        return (ti_r * tr + er) * cols + ti_c * tc + ec;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(int rows, int cols, int tr, int tc, bit down);
        cfg_rows      = 9'(rows);
        cfg_cols      = 9'(cols);
        cfg_tile_rows = 9'(tr);
        cfg_tile_cols = 9'(tc);
        cfg_walk_down = down;
    endtask

    task automatic run_frame(int rows, int cols, int tr, int tc, bit down, bit disturb, int ready_pct);
        int total, k, prev_addr, bad, exp_a;
        bit stalled;
        string tag;
        total = rows * cols;
        tag = down ? "R5/R3/R6" : "R4/R3/R6";
        @(negedge clk);
        set_cfg(rows, cols, tr, tc, down);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        set_cfg(rows + 1, cols, tr + 3, tc, !down);
        #1;
        // R2: valid in the cycle after start, error cleared
        check(addr_valid && busy && !cfg_err, "R2 start", int'({addr_valid, busy, cfg_err}), 6);
        k = 0; stalled = 1'b0; prev_addr = 0; bad = 0;
        while (k < total) begin
            addr_ready = (($urandom % 100) < ready_pct);
            start      = disturb && (k == 37 || k == 38);
            #1;
            exp_a = model_addr(k, rows, cols, tr, tc, down);
            if (!(addr_valid && int'(addr) == exp_a &&
                  tile_last == (((k + 1) % (tr * tc)) == 0) &&
                  frame_last == (k == total - 1))) begin
                bad++;
                check(1'b0, disturb ? "R10" : tag, int'(addr), exp_a);
            end
            if (stalled)
                // R8: held while stalled
                check(int'(addr) == prev_addr, "R8 hold", int'(addr), prev_addr);
            stalled   = !addr_ready;
            prev_addr = int'(addr);
            if (addr_ready) begin
                if (k < 4096) log_addr[k] = int'(addr);
                k++;
            end
            @(negedge clk);
        end
        start = 1'b0;
        addr_ready = 1'b0;
        if (bad == 0) check(1'b1, tag, 0, 0);
        #1;
        // R7: idle after the final handshake
        check(!addr_valid && !busy, "R7 end", int'({addr_valid, busy}), 0);
    endtask

    task automatic bad_cfg(int rows, int cols, int tr, int tc);
        @(negedge clk);
        set_cfg(rows, cols, tr, tc, 1'b0);
        start = 1'b1;
        addr_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R9: refused, no addresses offered
        check(cfg_err && !addr_valid && !busy, "R9 refuse", int'({cfg_err, addr_valid, busy}), 4);
        addr_ready = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual=%0d cycles expected=fewer", 190000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(!addr_valid && !busy && !cfg_err, "R1 reset", int'({addr_valid, busy, cfg_err}), 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(!addr_valid && !busy, "R1 idle", int'({addr_valid, busy}), 0);

        // R4 directed: left operand tiles 4x16
        run_frame(64, 64, 4, 16, 1'b0, 1'b0, 75);
        check(log_addr[64] == 16, "R4 second tile", log_addr[64], 16);
        check(log_addr[256] == 256, "R4 block row 2", log_addr[256], 256);
        check(log_addr[63] == 3 * 64 + 15, "R3 tile end", log_addr[63], 207);

        // R5 directed: right operand tiles 16x8
        run_frame(64, 64, 16, 8, 1'b1, 1'b0, 100);
        check(log_addr[128] == 1024, "R5 second tile", log_addr[128], 1024);
        check(log_addr[512] == 8, "R5 block column 2", log_addr[512], 8);

        // R9 refused settings, then R2 recovery
        bad_cfg(10, 16, 4, 4);
        bad_cfg(16, 12, 4, 8);
        bad_cfg(0, 16, 4, 4);
        bad_cfg(16, 16, 4, 0);
        run_frame(8, 8, 2, 4, 1'b0, 1'b0, 60);

        // R10: start and setting changes mid-frame
        run_frame(32, 16, 4, 8, 1'b1, 1'b1, 70);
        run_frame(16, 32, 8, 4, 1'b0, 1'b1, 70);

        // corner shapes: single-row, single-column, full-width tiles
        run_frame(6, 10, 1, 10, 1'b0, 1'b0, 50);
        run_frame(12, 5, 12, 1, 1'b1, 1'b0, 50);
        run_frame(1, 1, 1, 1, 1'b0, 1'b0, 50);
        run_frame(9, 9, 3, 3, 1'b1, 1'b0, 40);

        // random shapes
        for (int i = 0; i < 20; i++) begin
            int tr, tc, mr, mc;
            tr = 1 << ($urandom % 4);
            tc = 1 << ($urandom % 4);
            mr = 1 + ($urandom % 6);
            mc = 1 + ($urandom % 6);
            run_frame(tr * mr, tc * mc, tr, tc, 1'($urandom % 2), 1'b0, 50 + ($urandom % 50));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule